// File: doc/BRIEF.md
# I2C Master Byte Transfer Engine

This block sequences whole I2C master transfers one byte at a time. Software sets a control word, writes a 7-bit target address and, for reads, a byte count. The engine then places a START on the bus, sends the address with the direction bit, and moves data. Outgoing bytes come from a transmit FIFO. Incoming bytes land in a receive FIFO. Acknowledge bits are handled in both directions. The transfer ends either with a STOP or with the bus held, SCL low, ready for a repeated START.

The bus pins are open-drain. Each drive output pulls its line low when high, and the line inputs carry the resolved wire levels. Bit timing comes from an external strobe: each bit, START or STOP takes four strobes. A small monitor watches both lines for START and STOP conditions and keeps a bus-busy flag. The engine signals three events with single-cycle pulses: completion, receive-threshold and NACK.

Top module: `i2cm_xfer_engine`

## Requirements
- R1: After reset both drive outputs are low (lines released), bus_busy_o is 0, size_o is 0, and both FIFO-valid flags are 0.
- R2: A write transfer sends START, then the address with R/W=0, then every transmit-FIFO byte MSB first, each followed by an acknowledge slot read from the target. When the FIFO is empty and hold is clear, the engine sends STOP and pulses done_o once.
- R3: Control word fields are: bit 0 = read, bit 1 = master enable, bit 2 = 7-bit addressing, bit 3 = ACK enable, bit 4 = hold, bit 5 = monitor mode, bit 6 = FIFO clear. An address write starts a transfer only when bits 1 and 2 are set and bit 5 is clear. Otherwise the address write is ignored and the bus stays idle. A read waits after the address write until a nonzero count is written to size_i.
- R4: A read receives size_o bytes MSB first into the receive FIFO. It acknowledges every byte except the last, which it NACKs before ending. size_o drops by one as each byte is stored, reaches 0 at the end, and never rises except through size_we_i.
- R5: With control bit 3 clear, the engine NACKs every received byte.
- R6: A NACK in the address slot or in any written byte's slot ends the transfer with STOP. It pulses nack_o and does not pulse done_o. Unsent transmit bytes stay in the FIFO.
- R7: With control bit 4 set, the transfer ends without STOP: done_o pulses, SCL is held low and the bus stays busy. The next address write starts with a repeated START. Clearing bit 4 while the bus is held sends STOP.
- R8: Writing control bit 6 empties both FIFOs and clears the overflow flag in one cycle. The bit is not stored: a later control write without it leaves the FIFOs untouched.
- R9: rx_valid_o and tx_valid_o show that the receive and transmit FIFOs are not empty. rx_ovf_o is set, and the byte dropped, when a byte arrives while the receive FIFO is full.
- R10: data_o pulses once when the receive FIFO fill reaches FIFO_DEPTH-2.
- R11: SDA drive changes while SCL is released only for START and STOP. bus_busy_o rises after a START is seen on the lines and falls after a STOP.
- R12: Each FIFO holds FIFO_DEPTH (16) bytes. Pushes into a full transmit FIFO are dropped. Counts are SIZE_W (8) bits, so at most 255 bytes per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Quarter-bit timing strobe |
| ctrl_we_i | input | 1 | Control word write |
| ctrl_i | input | 7 | Control word |
| addr_we_i | input | 1 | Target address write (starts transfer) |
| addr_i | input | 7 | Target address |
| size_we_i | input | 1 | Byte count write |
| size_i | input | SIZE_W | Byte count for reads |
| txd_we_i | input | 1 | Push into transmit FIFO |
| txd_i | input | 8 | Transmit byte |
| rxd_re_i | input | 1 | Pop from receive FIFO |
| rxd_o | output | 8 | Head of receive FIFO |
| size_o | output | SIZE_W | Remaining read byte count |
| rx_valid_o | output | 1 | Receive FIFO not empty |
| tx_valid_o | output | 1 | Transmit FIFO not empty |
| rx_ovf_o | output | 1 | Receive overflow, sticky |
| bus_busy_o | output | 1 | Bus active between START and STOP |
| done_o | output | 1 | Completion pulse |
| data_o | output | 1 | Receive threshold pulse |
| nack_o | output | 1 | NACK pulse |
| scl_i | input | 1 | Resolved SCL line |
| sda_i | input | 1 | Resolved SDA line |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |

## Verification
The bench uses the default FIFO_DEPTH of 16 and SIZE_W of 8, with the strobe every fourth clock, against a behavioural target on the wired-AND lines. A depth of 16 keeps several boundary cases short enough to drive directly: 17 pushes overrun the transmit FIFO, a 17-byte read reaches the threshold at fill 14 and overflows, and a 20-byte read with popping shows the count falling. Write and read lengths are swept over short ranges. Read data comes from an arithmetic pattern the bench computes.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {BC_START, BC_STOP, BC_BIT} bit_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ARM, ST_START, ST_ADDR, ST_WNEXT,
    ST_WDATA, ST_RDATA, ST_STOP, ST_HOLD
  } eng_state_e;

  localparam int CB_RD     = 0;
  localparam int CB_MASTER = 1;
  localparam int CB_NORM   = 2;
  localparam int CB_ACKEN  = 3;
  localparam int CB_HOLD   = 4;
  localparam int CB_MON    = 5;
  localparam int CB_CLR    = 6;
endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic do_push, do_pop;

  assign full_o  = (count_o == CW'(DEPTH));
  assign empty_o = (count_o == '0);
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign rdata_o = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0; rptr <= '0; count_o <= '0;
    end else if (clr_i) begin
      wptr <= '0; rptr <= '0; count_o <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      if (do_push && !do_pop) count_o <= count_o + CW'(1);
      else if (do_pop && !do_push) count_o <= count_o - CW'(1);
    end
  end

  a_r8_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_o == '0));
  a_r12_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !clr_i) |=> $stable(count_o));
endmodule

// File: rtl/i2cm_bit_phy.sv
module i2cm_bit_phy
  import i2cm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     go_i,
  input  bit_cmd_e cmd_i,
  input  logic     txb_i,
  input  logic     sda_i,
  output logic     busy_o,
  output logic     done_o,
  output logic     rxb_o,
  output logic     scl_oe_o,
  output logic     sda_oe_o
);
  logic [1:0] q;
  bit_cmd_e   cmd_q;
  logic       txb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0; done_o <= 1'b0; rxb_o <= 1'b1;
      scl_oe_o <= 1'b0; sda_oe_o <= 1'b0;
      q <= '0; cmd_q <= BC_STOP; txb_q <= 1'b1;
    end else begin
      done_o <= 1'b0;
      if (go_i && !busy_o) begin
        busy_o <= 1'b1; q <= '0; cmd_q <= cmd_i; txb_q <= txb_i;
      end else if (busy_o && tick_i) begin
        q <= q + 2'd1;
        unique case (cmd_q)
          BC_START: case (q)
            2'd0: sda_oe_o <= 1'b0;
            2'd1: scl_oe_o <= 1'b0;
            2'd2: sda_oe_o <= 1'b1;   // SDA falls with SCL high
            default: scl_oe_o <= 1'b1;
          endcase
          BC_STOP: case (q)
            2'd0: begin scl_oe_o <= 1'b1; sda_oe_o <= 1'b1; end
            2'd1: scl_oe_o <= 1'b0;
            2'd2: sda_oe_o <= 1'b0;   // SDA rises with SCL high
            default: ;
          endcase
          default: case (q)
            2'd0: begin scl_oe_o <= 1'b1; sda_oe_o <= ~txb_q; end
            2'd1: scl_oe_o <= 1'b0;
            2'd2: rxb_o <= sda_i;
            default: scl_oe_o <= 1'b1;
          endcase
        endcase
        if (q == 2'd3) begin
          busy_o <= 1'b0; done_o <= 1'b1;
        end
      end
    end
  end

  a_r11_sda_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_o && !$past(scl_oe_o) && (sda_oe_o != $past(sda_oe_o)))
      |-> (cmd_q != BC_BIT));
endmodule

// File: rtl/i2cm_bus_mon.sv
module i2cm_bus_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic busy_o
);
  logic scl_d, sda_d, start_seen, stop_seen;

  assign start_seen = scl_i && scl_d && sda_d && !sda_i;
  assign stop_seen  = scl_i && scl_d && !sda_d && sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1; sda_d <= 1'b1; busy_o <= 1'b0;
    end else begin
      scl_d <= scl_i; sda_d <= sda_i;
      if (start_seen)     busy_o <= 1'b1;
      else if (stop_seen) busy_o <= 1'b0;
    end
  end

  a_r11_busy_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_seen |=> busy_o);
  a_r11_idle_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_seen |=> !busy_o);
endmodule

// File: rtl/i2cm_xfer_engine.sv
module i2cm_xfer_engine
  import i2cm_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int SIZE_W     = 8,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ctrl_we_i,
  input  logic [6:0]        ctrl_i,
  input  logic              addr_we_i,
  input  logic [6:0]        addr_i,
  input  logic              size_we_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              txd_we_i,
  input  logic [7:0]        txd_i,
  input  logic              rxd_re_i,
  output logic [7:0]        rxd_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              rx_valid_o,
  output logic              tx_valid_o,
  output logic              rx_ovf_o,
  output logic              bus_busy_o,
  output logic              done_o,
  output logic              data_o,
  output logic              nack_o,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  localparam logic [CW-1:0] THRESH_PRE = CW'(FIFO_DEPTH - 3);

  eng_state_e state;
  logic [5:0] ctrl_q;
  logic [6:0] addr_q;
  logic       rd_q, nacked, pend;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic       fifo_clr;

  // bit layer handshake
  logic     go, phy_busy, phy_done, phy_rxb, need_cmd, txb;
  bit_cmd_e cmd;

  // fifo wiring
  logic          tx_pop, tx_full, tx_empty;
  logic [7:0]    tx_rdata;
  logic [CW-1:0] tx_count, rx_count;
  logic          rx_push, rx_full, rx_empty;

  logic start_ok, last_byte;
  assign fifo_clr  = ctrl_we_i && ctrl_i[CB_CLR];
  assign start_ok  = ctrl_q[CB_MASTER] && ctrl_q[CB_NORM] && !ctrl_q[CB_MON];
  assign last_byte = (size_o == SIZE_W'(1));

  always_comb begin
    need_cmd = 1'b1;
    cmd      = BC_BIT;
    txb      = 1'b1;
    unique case (state)
      ST_START: cmd = BC_START;
      ST_STOP:  cmd = BC_STOP;
      ST_ADDR, ST_WDATA: txb = (bitcnt == 4'd8) ? 1'b1 : sh[7];
      ST_RDATA: txb = (bitcnt == 4'd8) ? (last_byte || !ctrl_q[CB_ACKEN]) : 1'b1;
      default:  need_cmd = 1'b0;
    endcase
  end
  assign go = need_cmd && !pend && !phy_busy;

  assign tx_pop  = (state == ST_WNEXT) && !tx_empty;
  assign rx_push = phy_done && (state == ST_RDATA) && (bitcnt == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE; ctrl_q <= '0; addr_q <= '0; rd_q <= 1'b0;
      nacked <= 1'b0; pend <= 1'b0; bitcnt <= '0; sh <= '0;
      size_o <= '0; rx_ovf_o <= 1'b0;
      done_o <= 1'b0; data_o <= 1'b0; nack_o <= 1'b0;
    end else begin
      done_o <= 1'b0; data_o <= 1'b0; nack_o <= 1'b0;
      if (ctrl_we_i) ctrl_q <= ctrl_i[5:0];
      if (go) pend <= 1'b1;
      else if (phy_done) pend <= 1'b0;

      if (fifo_clr) rx_ovf_o <= 1'b0;
      else if (rx_push && rx_full) rx_ovf_o <= 1'b1;
      if (rx_push && rx_count == THRESH_PRE) data_o <= 1'b1;

      if (size_we_i && state != ST_RDATA) size_o <= size_i;

      unique case (state)
        ST_IDLE, ST_HOLD: begin
          if (addr_we_i && start_ok) begin
            addr_q <= addr_i; rd_q <= ctrl_q[CB_RD]; nacked <= 1'b0;
            state  <= ctrl_q[CB_RD] ? ST_ARM : ST_START;
          end else if (state == ST_HOLD && !ctrl_q[CB_HOLD]) begin
            state <= ST_STOP;
          end
        end
        ST_ARM: if (size_we_i && size_i != '0) state <= ST_START;
        ST_START: if (phy_done) begin
          state <= ST_ADDR; bitcnt <= '0; sh <= {addr_q, rd_q};
        end
        ST_ADDR, ST_WDATA: if (phy_done) begin
          if (bitcnt != 4'd8) begin
            sh <= {sh[6:0], 1'b0}; bitcnt <= bitcnt + 4'd1;
          end else if (phy_rxb) begin
            nack_o <= 1'b1; nacked <= 1'b1; state <= ST_STOP;
          end else if (state == ST_ADDR && rd_q) begin
            state <= ST_RDATA; bitcnt <= '0;
          end else begin
            state <= ST_WNEXT;
          end
        end
        ST_WNEXT: begin
          if (!tx_empty) begin
            sh <= tx_rdata; bitcnt <= '0; state <= ST_WDATA;
          end else if (ctrl_q[CB_HOLD]) begin
            done_o <= 1'b1; state <= ST_HOLD;
          end else begin
            state <= ST_STOP;
          end
        end
        ST_RDATA: if (phy_done) begin
          if (bitcnt != 4'd8) begin
            sh <= {sh[6:0], phy_rxb}; bitcnt <= bitcnt + 4'd1;
          end else begin
            size_o <= size_o - SIZE_W'(1);
            bitcnt <= '0;
            if (last_byte) begin
              if (ctrl_q[CB_HOLD]) begin
                done_o <= 1'b1; state <= ST_HOLD;
              end else begin
                state <= ST_STOP;
              end
            end
          end
        end
        ST_STOP: if (phy_done) begin
          if (!nacked) done_o <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  i2cm_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk_i, .rst_ni, .clr_i(fifo_clr),
    .push_i(txd_we_i), .wdata_i(txd_i), .pop_i(tx_pop), .rdata_o(tx_rdata),
    .count_o(tx_count), .full_o(tx_full), .empty_o(tx_empty)
  );

  i2cm_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk_i, .rst_ni, .clr_i(fifo_clr),
    .push_i(rx_push), .wdata_i(sh), .pop_i(rxd_re_i), .rdata_o(rxd_o),
    .count_o(rx_count), .full_o(rx_full), .empty_o(rx_empty)
  );

  i2cm_bit_phy u_phy (
    .clk_i, .rst_ni, .tick_i, .go_i(go), .cmd_i(cmd), .txb_i(txb), .sda_i,
    .busy_o(phy_busy), .done_o(phy_done), .rxb_o(phy_rxb),
    .scl_oe_o, .sda_oe_o
  );

  i2cm_bus_mon u_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i, .busy_o(bus_busy_o)
  );

  assign rx_valid_o = !rx_empty;
  assign tx_valid_o = !tx_empty;

  logic unused_ok;
  assign unused_ok = ^{tx_count, tx_full};

  a_r6_nack_excl_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_o |-> !done_o);
  a_r4_size_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !size_we_i |=> (size_o <= $past(size_o)));
  a_r7_hold_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_HOLD) |-> scl_oe_o);
  a_r3_ignored_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && addr_we_i && !start_ok) |=> (state == ST_IDLE));
endmodule

// File: tb/i2cm_xfer_engine_test.sv
module i2cm_xfer_engine_test;
  localparam logic [6:0] SLV = 7'h5A;
  localparam logic [6:0] C_BASE = 7'd14;  // master | 7-bit | ack enable

  logic clk = 0, rst_ni = 0, tick_i = 0;
  logic ctrl_we_i = 0, addr_we_i = 0, size_we_i = 0, txd_we_i = 0, rxd_re_i = 0;
  logic [6:0] ctrl_i = 0, addr_i = 0;
  logic [7:0] size_i = 0, txd_i = 0;
  logic [7:0] rxd_o, size_o;
  logic rx_valid_o, tx_valid_o, rx_ovf_o, bus_busy_o, done_o, data_o, nack_o;
  logic scl_oe_o, sda_oe_o;
  logic s_pull = 0;
  wire scl_line = ~scl_oe_o;
  wire sda_line = ~(sda_oe_o | s_pull);

  i2cm_xfer_engine uut (
    .clk_i(clk), .rst_ni, .tick_i, .ctrl_we_i, .ctrl_i, .addr_we_i, .addr_i,
    .size_we_i, .size_i, .txd_we_i, .txd_i, .rxd_re_i, .rxd_o, .size_o,
    .rx_valid_o, .tx_valid_o, .rx_ovf_o, .bus_busy_o, .done_o, .data_o, .nack_o,
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe_o, .sda_oe_o
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0, tcnt = 0;
  int done_cnt = 0, nack_cnt = 0, data_cnt = 0;

  always @(negedge clk) begin
    cyc++;
    tcnt++;
    tick_i <= (tcnt % 4 == 0);
    if (rst_ni) begin
      if (done_o) done_cnt++;
      if (nack_o) nack_cnt++;
      if (data_o) data_cnt++;
    end
    if (cyc == 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // behavioural target
  int s_bit = 0, s_starts = 0, s_stops = 0, wr_n = 0, rd_idx = 0;
  int m_acks = 0, m_nacks = 0;
  logic s_active = 0, s_addr_phase = 0, s_rdmode = 0, s_rdnext = 0;
  logic s_ack_ok = 0, s_mack = 0, s_sending = 0;
  logic [7:0] s_sh = 0, s_txb = 0;
  logic [7:0] wr_mem [32];

  function automatic logic [7:0] rd_val(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  always @(negedge sda_line) if (scl_line === 1'b1 && rst_ni) begin
    s_active = 1; s_bit = 0; s_addr_phase = 1; s_rdmode = 0; s_sending = 0;
    s_starts++;
  end
  always @(posedge sda_line) if (scl_line === 1'b1 && rst_ni) begin
    s_active = 0; s_stops++;
  end
  always @(posedge scl_line) if (s_active) begin
    s_bit++;
    if (s_bit <= 8) s_sh = {s_sh[6:0], sda_line};
    else if (s_rdmode) begin
      s_mack = !sda_line;
      if (sda_line) m_nacks++; else m_acks++;
    end
  end
  always @(negedge scl_line) if (s_active) begin
    if (s_bit == 8) begin
      if (s_addr_phase) begin
        s_ack_ok = (s_sh[7:1] == SLV); s_rdnext = s_sh[0]; s_pull = s_ack_ok;
      end else if (!s_rdmode) begin
        if (wr_n < 32) wr_mem[wr_n] = s_sh;
        wr_n++;
        s_pull = (s_sh != 8'hEE);
      end else s_pull = 0;
    end else if (s_bit == 9) begin
      s_bit = 0;
      if (s_addr_phase) begin
        s_addr_phase = 0; s_rdmode = s_rdnext; s_sending = s_ack_ok && s_rdnext;
        if (!s_ack_ok) s_active = 0;
      end else if (s_rdmode) s_sending = s_mack;
      if (s_sending) begin
        s_txb = rd_val(rd_idx); rd_idx++; s_pull = ~s_txb[7];
      end else s_pull = 0;
    end else if (s_rdmode && s_sending && s_bit >= 1 && s_bit <= 7) begin
      s_pull = ~s_txb[7 - s_bit];
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [6:0] v);
    ctrl_i = v; ctrl_we_i = 1; @(negedge clk); ctrl_we_i = 0;
  endtask
  task automatic wr_addr(input logic [6:0] a);
    addr_i = a; addr_we_i = 1; @(negedge clk); addr_we_i = 0;
  endtask
  task automatic wr_size(input int n);
    size_i = 8'(n); size_we_i = 1; @(negedge clk); size_we_i = 0;
  endtask
  task automatic push(input logic [7:0] b);
    txd_i = b; txd_we_i = 1; @(negedge clk); txd_we_i = 0;
  endtask
  task automatic pop(output logic [7:0] b);
    b = rxd_o; rxd_re_i = 1; @(negedge clk); rxd_re_i = 0;
  endtask
  task automatic wait_evt();
    int d0 = done_cnt, n0 = nack_cnt, t = 0;
    while (done_cnt == d0 && nack_cnt == n0 && t < 30000) begin
      @(negedge clk); t++;
    end
    if (t >= 30000) chk("R2 event timeout", 0, 1);
    repeat (60) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    int base, st0, sp0, d0, n0, popped;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 scl_oe", scl_oe_o, 0);
    chk("R1 sda_oe", sda_oe_o, 0);
    chk("R1 busy", bus_busy_o, 0);
    chk("R1 size", size_o, 0);
    chk("R1 rx_valid", rx_valid_o, 0);
    chk("R1 tx_valid", tx_valid_o, 0);

    // R3 start blocked by missing master bit, missing 7-bit bit, monitor bit
    foreach (base_ctrls[i]) begin
      wr_ctrl(base_ctrls[i]);
      wr_addr(SLV);
      repeat (200) @(negedge clk);
      chk("R3 ignored addr starts", s_starts, 0);
      chk("R3 ignored addr scl", scl_oe_o, 0);
    end

    // R2 write sweep over lengths 1..5
    wr_ctrl(C_BASE);
    for (int n = 1; n <= 5; n++) begin
      wr_n = 0; sp0 = s_stops; d0 = done_cnt;
      for (int k = 0; k < n; k++) push(8'(n * 16 + k * 3 + 1));
      chk("R9 tx_valid set", tx_valid_o, 1);
      wr_addr(SLV);
      wait_evt();
      chk("R2 byte count", wr_n, n);
      for (int k = 0; k < n; k++) chk("R2 byte value", wr_mem[k], n * 16 + k * 3 + 1);
      chk("R2 stop", s_stops, sp0 + 1);
      chk("R2 done once", done_cnt, d0 + 1);
      chk("R9 tx_valid clear", tx_valid_o, 0);
      chk("R11 busy after stop", bus_busy_o, 0);
    end

    // R12 transmit FIFO holds 16, 17th push dropped
    wr_n = 0;
    for (int k = 0; k < 17; k++) push(8'(k + 100));
    wr_addr(SLV);
    wait_evt();
    chk("R12 tx depth", wr_n, 16);
    chk("R12 last kept", wr_mem[15], 115);

    // R6 address NACK
    sp0 = s_stops; d0 = done_cnt; n0 = nack_cnt;
    push(8'h42);
    wr_addr(7'h11);
    wait_evt();
    chk("R6 nack pulse", nack_cnt, n0 + 1);
    chk("R6 no done", done_cnt, d0);
    chk("R6 stop", s_stops, sp0 + 1);
    chk("R6 byte kept", tx_valid_o, 1);
    // R8 clear flushes, bit not stored
    wr_ctrl(C_BASE | 7'h40);
    chk("R8 tx flushed", tx_valid_o, 0);
    push(8'h33);
    wr_ctrl(C_BASE);
    chk("R8 clear not stored", tx_valid_o, 1);
    wr_ctrl(C_BASE | 7'h40);

    // R6 data NACK on 0xEE
    wr_n = 0; n0 = nack_cnt; d0 = done_cnt;
    push(8'h10); push(8'hEE); push(8'h20);
    wr_addr(SLV);
    wait_evt();
    chk("R6 data nack pulse", nack_cnt, n0 + 1);
    chk("R6 data nack no done", done_cnt, d0);
    chk("R6 bytes sent", wr_n, 2);
    chk("R6 rest kept", tx_valid_o, 1);
    wr_ctrl(C_BASE | 7'h40);

    // R4 read sweep lengths 1..6
    wr_ctrl(C_BASE | 7'h01);
    for (int n = 1; n <= 6; n++) begin
      base = rd_idx; m_acks = 0; m_nacks = 0; st0 = s_starts;
      wr_addr(SLV);
      repeat (100) @(negedge clk);
      chk("R3 read waits for size", s_starts, st0);
      wr_size(n);
      wait_evt();
      chk("R4 size zero", size_o, 0);
      chk("R4 acks", m_acks, n - 1);
      chk("R4 final nack", m_nacks, 1);
      for (int k = 0; k < n; k++) begin
        pop(v);
        chk("R4 read value", v, rd_val(base + k));
      end
      chk("R9 rx drained", rx_valid_o, 0);
    end

    // R4 countdown with concurrent popping
    base = rd_idx; popped = 0; d0 = data_cnt;
    wr_addr(SLV);
    wr_size(20);
    for (int t = 0; t < 40000 && popped < 20; t++) begin
      @(negedge clk);
      if (rx_valid_o) begin
        chk("R4 countdown", size_o, 20 - (popped + 1));
        pop(v);
        chk("R4 streamed value", v, rd_val(base + popped));
        popped++;
      end
    end
    repeat (200) @(negedge clk);
    chk("R4 streamed count", popped, 20);
    chk("R10 no threshold when drained", data_cnt, d0);

    // R10 threshold, R9 overflow on 17-byte read
    base = rd_idx; d0 = data_cnt;
    wr_addr(SLV);
    wr_size(17);
    wait_evt();
    chk("R10 threshold once", data_cnt, d0 + 1);
    chk("R9 overflow", rx_ovf_o, 1);
    for (int k = 0; k < 16; k++) begin
      pop(v);
      chk("R12 rx kept", v, rd_val(base + k));
    end
    chk("R9 rx empty", rx_valid_o, 0);
    wr_ctrl(C_BASE | 7'h41);
    chk("R8 overflow cleared", rx_ovf_o, 0);

    // R5 ack generation off
    wr_ctrl(7'h07);
    base = rd_idx; m_nacks = 0; m_acks = 0;
    wr_addr(SLV);
    wr_size(2);
    wait_evt();
    chk("R5 all nack", m_nacks, 2);
    chk("R5 no ack", m_acks, 0);
    pop(v); chk("R5 first byte", v, rd_val(base));
    pop(v); chk("R5 released bus byte", v, 255);

    // R7 hold then repeated START
    wr_ctrl(C_BASE | 7'h10);
    sp0 = s_stops; st0 = s_starts; wr_n = 0;
    push(8'h5C); push(8'h7E);
    wr_addr(SLV);
    wait_evt();
    chk("R7 no stop", s_stops, sp0);
    chk("R7 scl held", scl_oe_o, 1);
    chk("R7 busy held", bus_busy_o, 1);
    chk("R7 write bytes", wr_n, 2);
    wr_ctrl(C_BASE | 7'h11);
    base = rd_idx;
    wr_addr(SLV);
    wr_size(3);
    wait_evt();
    chk("R7 repeated start", s_starts, st0 + 2);
    chk("R7 still no stop", s_stops, sp0);
    for (int k = 0; k < 3; k++) begin
      pop(v);
      chk("R7 read after restart", v, rd_val(base + k));
    end
    wr_ctrl(C_BASE | 7'h01);
    repeat (120) @(negedge clk);
    chk("R7 stop on release", s_stops, sp0 + 1);
    chk("R11 busy cleared", bus_busy_o, 0);
    chk("R7 scl released", scl_oe_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // R3 control words that must not start a transfer
  logic [6:0] base_ctrls [3] = '{7'h0C, 7'h0A, 7'h2E};
endmodule